// File: doc/BRIEF.md
# Weighted Pseudo-Random Test Pattern Generator

This block supplies test vectors for a logic self-test in which individual vector bits are deliberately skewed toward 1 or toward 0. Some faults, such as a stuck-at-0 on the output of a wide AND gate, almost never show up under evenly distributed random bits. A free-running linear feedback shift register (LFSR) provides bits that are treated as independent, each equally likely to be 0 or 1. Every output bit then combines a small group of those bits. If the group is ANDed, the probability of a 1 is 0.5^k. If it is ORed, the probability of a 1 is 1-0.5^k. A single tap gives an unbiased bit.

The 3-bit bias codes for all output bits make up one weight set. Several weight sets are held as elaboration-time parameters, because computing them is done elsewhere. Each set has its own pattern budget. While the block is enabled, a controller emits the budgeted number of patterns from the current set and then moves on to the next set, wrapping from the last set back to the first. While the block is disabled, the LFSR holds its state, and the set chosen on `set_sel` is loaded together with a fresh budget.

Top module: `wpg_top`

## Requirements
- R1: While `rst` is high at a clock edge, the LFSR is loaded with SEED (default 16'hACE1), the active set becomes 0 and the pattern count is cleared. `vec` is then the set-0 pattern computed from SEED.
- R2: On each rising edge with `en` high, the LFSR shifts left by one place. Bit 0 takes the XOR of the state bits selected by TAPS (default 16'hB400, bits 15, 13, 12 and 10). With `en` low, the LFSR state and `vec` hold, provided `set_sel` does not change.
- R3: Output bit i uses the taps t0..t4. Tap tj is LFSR stage (i*STRIDE + j) mod LFSR_W, with STRIDE defaulting to 5.
- R4: For bias codes 1, 2 and 3 (bit 2 clear), the output bit is the AND of taps t0..t1, t0..t2 and t0..t4 respectively.
- R5: For bias codes 5, 6 and 7 (bit 2 set), the output bit is the OR of taps t0..t1, t0..t2 and t0..t4 respectively.
- R6: Bias codes 0 and 4 pass tap t0 through unchanged.
- R7: Set s is in force for exactly COUNTS[s] consecutive enabled cycles. Set s occupies bits [s*16 +: 16] of COUNTS. When that count is reached, the active set advances to s+1, and to 0 after the last set.
- R8: At each edge with `en` low, the active set is loaded from `set_sel` and the pattern count is cleared. A `set_sel` value of NUM_SETS or more selects set 0.
- R9: The LFSR never holds the all-zero state.
- R10: The bias codes for set s occupy bits [s*VEC_W*3 +: VEC_W*3] of WEIGHTS, with bit i's code at bits [3i +: 3] of that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the LFSR and the pattern budget by one pattern per cycle |
| set_sel | input | SEL_W | Weight set loaded while `en` is low |
| vec | output | VEC_W | Current weighted test vector |

## Verification
`vec` is decoded without a register from the LFSR state and the active set. Each edge therefore shows its effect on `vec` within the same clock period. The bench compares `vec` against its own model at the falling edge that follows every rising edge. Inputs are driven just after that comparison, so every value the model uses is the one that was stable at the preceding rising edge. Set changes, budget wrap-around and the hold while disabled all show up on `vec` at that same falling edge, with no added latency.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
   localparam int CODE_W = 3;
   localparam int MAX_SPAN = 5;

   typedef enum logic [1:0] {
      SPAN_1 = 2'd0,
      SPAN_2 = 2'd1,
      SPAN_3 = 2'd2,
      SPAN_5 = 2'd3
   } span_e;

   typedef struct packed {
      logic  use_or;
      span_e span;
   } bias_code_t;
endpackage

// File: rtl/wpg_lfsr.sv
module wpg_lfsr #(
   parameter int          W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400,
   parameter logic [W-1:0] SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   output logic [W-1:0] state
);
   if (SEED == '0) begin : g_bad_seed
      $error("wpg_lfsr: SEED must be nonzero");
   end
   if (TAPS[W-1] != 1'b1) begin : g_bad_taps
      $error("wpg_lfsr: TAPS must include the top stage");
   end

   logic fb;
   assign fb = ^(state & TAPS);

   always_ff @(posedge clk) begin
      if (rst)       state <= SEED;
      else if (step) state <= {state[W-2:0], fb};
   end

   assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
      state != '0);
   assert_lfsr_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(state));
endmodule

// File: rtl/wpg_bit.sv
module wpg_bit
   import wpg_pkg::*;
#(
   parameter int W    = 16,
   parameter int BASE = 0
) (
   input  logic [W-1:0]      state,
   input  logic [CODE_W-1:0] code,
   output logic              bit_o
);
   logic [MAX_SPAN-1:0] t;
   bias_code_t c;
   logic and_v, or_v;

   for (genvar j = 0; j < MAX_SPAN; j++) begin : g_tap
      localparam int IDX = (BASE + j) % W;
      assign t[j] = state[IDX];
   end

   assign c = bias_code_t'(code);

   always_comb begin
      unique case (c.span)
         SPAN_1: begin and_v = t[0];      or_v = t[0];      end
         SPAN_2: begin and_v = &t[1:0];   or_v = |t[1:0];   end
         SPAN_3: begin and_v = &t[2:0];   or_v = |t[2:0];   end
         default: begin and_v = &t[4:0];  or_v = |t[4:0];   end
      endcase
      bit_o = c.use_or ? or_v : and_v;
   end
endmodule

// File: rtl/wpg_ctrl.sv
module wpg_ctrl #(
   parameter int NUM_SETS = 4,
   parameter int SEL_W    = 2,
   parameter int CNT_W    = 16,
   parameter logic [NUM_SETS*CNT_W-1:0] COUNTS = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [SEL_W-1:0] set_sel,
   output logic [SEL_W-1:0] cur_set
);
   localparam logic [SEL_W-1:0] LAST_SET = SEL_W'(NUM_SETS - 1);

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
      if (COUNTS[s*CNT_W +: CNT_W] == '0) begin : g_zero
         $error("wpg_ctrl: every set needs a nonzero pattern budget");
      end
   end

   logic [CNT_W-1:0] count, limit;
   logic [SEL_W-1:0] sel_ok, nxt_set;
   logic             last_pat;

   assign limit    = COUNTS[32'(cur_set)*CNT_W +: CNT_W];
   assign last_pat = (count == limit - 1'b1);
   assign sel_ok   = (32'(set_sel) < NUM_SETS) ? set_sel : '0;
   assign nxt_set  = (cur_set == LAST_SET) ? '0 : cur_set + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_set <= '0;
         count   <= '0;
      end else if (!en) begin
         cur_set <= sel_ok;
         count   <= '0;
      end else if (last_pat) begin
         cur_set <= nxt_set;
         count   <= '0;
      end else begin
         count   <= count + 1'b1;
      end
   end

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
      count < limit);
   assert_set_range_R7: assert property (@(posedge clk) disable iff (rst)
      32'(cur_set) < NUM_SETS);
   assert_budget_wrap_R7: assert property (@(posedge clk) disable iff (rst)
      (en && last_pat) |=> (count == '0 && cur_set != $past(cur_set)));
   assert_idle_load_R8: assert property (@(posedge clk) disable iff (rst)
      !en |=> (count == '0));
endmodule

// File: rtl/wpg_top.sv
module wpg_top
   import wpg_pkg::*;
#(
   parameter int LFSR_W   = 16,
   parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
   parameter int VEC_W    = 8,
   parameter int STRIDE   = 5,
   parameter int NUM_SETS = 4,
   parameter int CNT_W    = 16,
   parameter logic [NUM_SETS*VEC_W*CODE_W-1:0] WEIGHTS =
      96'o01234567_77777777_33333333_76543210,
   parameter logic [NUM_SETS*CNT_W-1:0] COUNTS =
      {16'd3, 16'd5, 16'd4, 16'd6},
   localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [SEL_W-1:0] set_sel,
   output logic [VEC_W-1:0] vec
);
   localparam int SET_BITS = VEC_W * CODE_W;

   if (LFSR_W < MAX_SPAN) begin : g_bad_w
      $error("wpg_top: LFSR_W must be at least MAX_SPAN");
   end
   if (NUM_SETS < 2) begin : g_bad_sets
      $error("wpg_top: NUM_SETS must be at least 2");
   end

   logic [LFSR_W-1:0]   state;
   logic [SEL_W-1:0]    cur_set;
   logic [SET_BITS-1:0] cur_w;

   wpg_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
      .clk(clk), .rst(rst), .step(en), .state(state)
   );

   wpg_ctrl #(.NUM_SETS(NUM_SETS), .SEL_W(SEL_W), .CNT_W(CNT_W),
              .COUNTS(COUNTS)) u_ctrl (
      .clk(clk), .rst(rst), .en(en), .set_sel(set_sel), .cur_set(cur_set)
   );

   assign cur_w = WEIGHTS[32'(cur_set)*SET_BITS +: SET_BITS];

   for (genvar i = 0; i < VEC_W; i++) begin : g_bit
      wpg_bit #(.W(LFSR_W), .BASE((i * STRIDE) % LFSR_W)) u_bit (
         .state(state),
         .code(cur_w[i*CODE_W +: CODE_W]),
         .bit_o(vec[i])
      );
   end

   assert_vec_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!en && $stable(set_sel) && (cur_set == set_sel)) |=> $stable(vec));
endmodule

// File: tb/tb_wpg_top.sv
module tb_wpg_top;
   localparam int CLK_P = 10;
   localparam int LW = 16;
   localparam int VW = 8;
   localparam int NS = 4;
   localparam int STR = 5;
   localparam logic [LW-1:0] M_TAPS = 16'hB400;
   localparam logic [LW-1:0] M_SEED = 16'hACE1;
   localparam logic [NS*VW*3-1:0] M_W = 96'o01234567_77777777_33333333_76543210;
   localparam logic [NS*16-1:0]   M_C = {16'd3, 16'd5, 16'd4, 16'd6};

   logic clk = 0, rst = 1, en = 0;
   logic [1:0] set_sel = 0;
   logic [VW-1:0] vec;
   int checks = 0, fails = 0;
   bit done = 0;

   logic [LW-1:0] m_lfsr;
   int m_set, m_cnt;
   int ones_and5, bits_and5, ones_or5, bits_or5;

   always #(CLK_P/2) clk = ~clk;

   wpg_top #(.LFSR_W(LW), .TAPS(M_TAPS), .SEED(M_SEED), .VEC_W(VW), .STRIDE(STR),
             .NUM_SETS(NS), .CNT_W(16), .WEIGHTS(M_W), .COUNTS(M_C)) dut (
      .clk(clk), .rst(rst), .en(en), .set_sel(set_sel), .vec(vec)
   );

   function automatic logic [VW-1:0] exp_vec(logic [LW-1:0] s, int set);
      logic [VW-1:0] r;
      for (int i = 0; i < VW; i++) begin
         logic [2:0] code;
         int n;
         logic a, o;
         code = M_W[set*VW*3 + i*3 +: 3];
         case (code[1:0]) 2'd0: n = 1; 2'd1: n = 2; 2'd2: n = 3; default: n = 5; endcase
         a = 1; o = 0;
         for (int j = 0; j < n; j++) begin
            a = a & s[(i*STR + j) % LW];
            o = o | s[(i*STR + j) % LW];
         end
         r[i] = code[2] ? o : a;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_lfsr <= M_SEED; m_set <= 0; m_cnt <= 0;
      end else if (!en) begin
         m_set <= (int'(set_sel) < NS) ? int'(set_sel) : 0; m_cnt <= 0;
      end else begin
         m_lfsr <= {m_lfsr[LW-2:0], ^(m_lfsr & M_TAPS)};
         if (m_cnt == int'(M_C[m_set*16 +: 16]) - 1) begin
            m_cnt <= 0; m_set <= (m_set + 1) % NS;
         end else m_cnt <= m_cnt + 1;
      end
   end

   task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: vec=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc_check(string req);
      @(negedge clk);
      check(req, vec, exp_vec(m_lfsr, m_set));
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] held;
      void'($urandom(32'd1234));
      ones_and5 = 0; bits_and5 = 0; ones_or5 = 0; bits_or5 = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1: reset state gives the set-0 pattern of the seed
      check("R1 reset", vec, exp_vec(M_SEED, 0));
      rst = 0;
      en = 1;
      // R7 R10: run past the sum of all budgets to see every set and the wrap
      for (int k = 0; k < 40; k++) cyc_check("R7 R10 budget sequence");
      // R8: idle load of a chosen set, then a held state
      en = 0; set_sel = 2;
      cyc_check("R8 idle set load");
      held = vec;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R2 hold while disabled", vec, held);
      end
      // R8: out-of-range select is impossible at 2 bits with 4 sets; select set 3
      set_sel = 3;
      cyc_check("R8 idle set load 3");
      en = 1;
      for (int k = 0; k < 10; k++) cyc_check("R2 R7 after idle");
      // Random phase: R2 R3 R4 R5 R6 against the model
      for (int k = 0; k < 4000; k++) begin
         en = ($urandom_range(0, 99) < 85);
         set_sel = 2'($urandom_range(0, 3));
         @(negedge clk);
         check("R2 R3 R4 R5 R6 random", vec, exp_vec(m_lfsr, m_set));
         if (m_set == 1) begin ones_and5 += $countones(vec); bits_and5 += VW; end
         if (m_set == 2) begin ones_or5  += $countones(vec); bits_or5  += VW; end
      end
      // R4: five-way AND bias gives few ones
      checks++;
      if (bits_and5 == 0 || ones_and5 * 100 > bits_and5 * 12) begin
         fails++;
         $display("FAIL R4 and5 bias: ones=%0d of %0d expected below 12%%", ones_and5, bits_and5);
      end
      // R5: five-way OR bias gives mostly ones
      checks++;
      if (bits_or5 == 0 || ones_or5 * 100 < bits_or5 * 88) begin
         fails++;
         $display("FAIL R5 or5 bias: ones=%0d of %0d expected above 88%%", ones_or5, bits_or5);
      end
      // R9 R1: a mid-run reset returns to the seed pattern
      rst = 1;
      @(negedge clk);
      check("R1 R9 re-reset", vec, exp_vec(M_SEED, 0));
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule